// File: doc/BRIEF.md
# Banked GPIO Port Register File

This block is a memory-mapped controller for general-purpose I/O pads. The lines are grouped into banks of eight. Each bank has two byte-wide registers. The data register holds the output latch and reads back the line level. The direction register selects, line by line, whether the pad is driven or only sampled. A simple register bus with address, write enable, write data and registered read data reaches the bank registers.

Bank register blocks sit at eight-byte steps. A sixteen-byte window that belongs to a neighbouring interrupt block is left out of the map, so every bank whose base would fall at or above that window moves past it. Pad inputs are resynchronised before readback. Output enables and output values go straight from flip-flops to the pads.

Top module: `gpio_bank_regfile`

## Requirements
- R1: After a synchronous reset every output enable and every output value is 0, and each direction register reads 0xFF, meaning all lines are inputs.
- R2: Line n of the pad vectors belongs to bank n/8, at bit n mod 8 of that bank's registers.
- R3: Bank b has its base at (b+1)*8, before any gap adjustment. Its data register is at base+0 and its direction register at base+4.
- R4: A base that comes out at 0x90 or above is raised by 0x10. Addresses 0x90 to 0x9F therefore reach no bank, and writes to them change no pad output.
- R5: A direction bit of 1 makes its line an input, with the output enable low. A direction bit of 0 makes the line an output, with the output enable high.
- R6: A data-register read returns the output latch bit for output lines and the synchronised pad level for input lines.
- R7: Writing the data register of an input line loads its latch without enabling the pad. A later switch of the line to output drives the preloaded value from the first cycle. Pad outputs change only in the cycle after a bus write.
- R8: An address that matches no implemented register reads as 0 and ignores writes. Such addresses include addresses beyond the last bank and addresses not aligned to a register.
- R9: A pad level reaches read data three clock edges after it changes: two synchroniser stages, then the read register.
- R10: Read data is registered. It reflects the address presented one clock edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | NUM_BANKS*8 | Pad levels, sampled asynchronously |
| pad_oe | output | NUM_BANKS*8 | Per-line output enable |
| pad_out | output | NUM_BANKS*8 | Per-line output value |

## Verification
A write takes effect at the clock edge that samples it. The bench drives each write half a period before that edge and checks pad_oe and pad_out half a period after it. A read result is due one edge after the address, so the bench samples bus_rdata at the next falling edge. For pad inputs, the bench holds the address steady and checks read data after two edges, when the old value must still show, and again after three edges, when the new level must show.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int LINES_PER_BANK = 8;
  localparam int BANK_STRIDE    = 8;
  localparam int HOLE_START     = 'h90;
  localparam int HOLE_BYTES     = 'h10;
  localparam int DIR_OFFSET     = 4;

  // Base byte address of a bank, skipping the reserved interrupt window.
  function automatic int bank_base(input int b);
    int base;
    base = (b + 1) * BANK_STRIDE;
    if (base >= HOLE_START) base = base + HOLE_BYTES;
    return base;
  endfunction
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 20,
  parameter int ADDR_W    = 8
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_BANKS-1:0] data_hit,
  output logic [NUM_BANKS-1:0] dir_hit
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cmp
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(bank_base(b));
    localparam logic [ADDR_W-1:0] DIR_A  = ADDR_W'(bank_base(b) + DIR_OFFSET);
    assign data_hit[b] = (addr == DATA_A);
    assign dir_hit[b]  = (addr == DIR_A);
  end
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_data,
  input  logic             wr_dir,
  input  logic [LINES-1:0] wdata,
  input  logic [LINES-1:0] pad_sync,
  output logic [LINES-1:0] out_latch,
  output logic [LINES-1:0] out_en,
  output logic [LINES-1:0] data_view,
  output logic [LINES-1:0] dir_view
);
  // Stored as enables (reset 0) so the pad enable comes straight off a flop.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_latch <= '0;
      out_en    <= '0;
    end else begin
      if (wr_data) out_latch <= wdata;
      if (wr_dir)  out_en    <= ~wdata;
    end
  end

  assign data_view = (out_latch & out_en) | (pad_sync & ~out_en);
  assign dir_view  = ~out_en;
endmodule

// File: rtl/gpio_bank_regfile.sv
module gpio_bank_regfile
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 20,
  parameter int ADDR_W    = 8,
  localparam int LINES    = LINES_PER_BANK,
  localparam int NLINES   = NUM_BANKS * LINES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [LINES-1:0]  bus_wdata,
  output logic [LINES-1:0]  bus_rdata,
  input  logic [NLINES-1:0] pad_in,
  output logic [NLINES-1:0] pad_oe,
  output logic [NLINES-1:0] pad_out
);
  logic [NUM_BANKS-1:0] data_hit, dir_hit;
  logic [NLINES-1:0]    pad_sync;
  logic [LINES-1:0]     data_view [NUM_BANKS];
  logic [LINES-1:0]     dir_view  [NUM_BANKS];
  logic [LINES-1:0]     rd_next;

  gpio_addr_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) dec_i (
    .addr     (bus_addr),
    .data_hit (data_hit),
    .dir_hit  (dir_hit)
  );

  gpio_sync2 #(.W(NLINES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (pad_sync)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_bank #(.LINES(LINES)) bank_i (
      .clk       (clk),
      .rst       (rst),
      .wr_data   (bus_we & data_hit[b]),
      .wr_dir    (bus_we & dir_hit[b]),
      .wdata     (bus_wdata),
      .pad_sync  (pad_sync[b*LINES +: LINES]),
      .out_latch (pad_out[b*LINES +: LINES]),
      .out_en    (pad_oe[b*LINES +: LINES]),
      .data_view (data_view[b]),
      .dir_view  (dir_view[b])
    );
  end

  // Hits are one-hot or empty; an empty select reads zero.
  always_comb begin
    rd_next = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (data_hit[b]) rd_next = rd_next | data_view[b];
      if (dir_hit[b])  rd_next = rd_next | dir_view[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end
endmodule

// File: rtl/gpio_bank_regfile_chk.sv
module gpio_bank_regfile_chk
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 20,
  parameter int ADDR_W    = 8,
  localparam int NLINES   = NUM_BANKS * LINES_PER_BANK
) (
  input logic                      clk,
  input logic                      rst,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic                      bus_we,
  input logic [LINES_PER_BANK-1:0] bus_rdata,
  input logic [NLINES-1:0]         pad_oe,
  input logic [NLINES-1:0]         pad_out
);
  logic in_hole;
  assign in_hole = (int'(bus_addr) >= HOLE_START) &&
                   (int'(bus_addr) < HOLE_START + HOLE_BYTES);

  // R1: leaving reset, no pad is driven
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pad_oe == '0) && (pad_out == '0));

  // R4: a write into the reserved window touches no pad
  assert_hole_write_R4: assert property (@(posedge clk) disable iff (rst)
    (in_hole && bus_we) |=> $stable(pad_oe) && $stable(pad_out));

  // R8: the reserved window reads as zero
  assert_hole_read_R8: assert property (@(posedge clk) disable iff (rst)
    in_hole |=> (bus_rdata == '0));

  // R7: pads move only after a bus write
  assert_pads_only_on_write_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bus_we)) |-> $stable(pad_oe) && $stable(pad_out));
endmodule

bind gpio_bank_regfile gpio_bank_regfile_chk #(
  .NUM_BANKS (NUM_BANKS),
  .ADDR_W    (ADDR_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_rdata (bus_rdata),
  .pad_oe    (pad_oe),
  .pad_out   (pad_out)
);

// File: tb/gpio_bank_regfile_tb.sv
`timescale 1ns/100ps
module gpio_bank_regfile_tb_top;
  localparam int NB = 20;
  localparam int AW = 8;
  localparam int NL = NB * 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic [NL-1:0] pad_in = '0;
  logic [NL-1:0] pad_oe, pad_out;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  gpio_bank_regfile #(.NUM_BANKS(NB), .ADDR_W(AW)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out)
  );

  // {write addr, write data, read addr, expected read}
  localparam logic [31:0] VEC [8] = '{
    {8'h0C, 8'h00, 8'h0C, 8'h00},  // R3 R5: bank 0 all outputs
    {8'h08, 8'hA5, 8'h08, 8'hA5},  // R6: output lines read latch
    {8'h8C, 8'h0F, 8'h8C, 8'h0F},  // R3: bank 16 direction
    {8'h88, 8'hFF, 8'h88, 8'hF0},  // R6: mixed lines, inputs read pad 0
    {8'h9C, 8'h00, 8'h9C, 8'h00},  // R4 R8: reserved window
    {8'hA4, 8'h00, 8'hA4, 8'h00},  // R4: bank 17 moved past window
    {8'hA0, 8'h3C, 8'hA0, 8'h3C},  // R4: bank 17 data
    {8'hB4, 8'h55, 8'hB4, 8'h55}   // R3: last bank direction
  };

  task automatic check(input string tag, input logic [NL-1:0] act, input logic [NL-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    v = bus_rdata;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0]    rv;
    logic [NL-1:0] exp_oe, exp_out;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 pad_oe after reset", pad_oe, '0);
    check("R1 pad_out after reset", pad_out, '0);
    bus_read(8'h0C, rv);
    check("R1 direction reads all inputs", NL'(rv), NL'(8'hFF));

    // Table walk
    for (int i = 0; i < 8; i++) begin
      bus_write(VEC[i][31:24], VEC[i][23:16]);
      bus_read(VEC[i][15:8], rv);
      check($sformatf("R3/R4/R6 vector %0d", i), NL'(rv), NL'(VEC[i][7:0]));
    end

    // R2 R5: line placement on the pads
    exp_oe = '0; exp_out = '0;
    exp_oe[7:0] = 8'hFF;       exp_out[7:0] = 8'hA5;
    exp_oe[135:128] = 8'hF0;   exp_out[135:128] = 8'hFF;
    exp_oe[143:136] = 8'hFF;   exp_out[143:136] = 8'h3C;
    exp_oe[159:152] = 8'hAA;
    check("R2 R5 R4 pad_oe map", pad_oe, exp_oe);
    check("R2 pad_out map", pad_out, exp_out);

    // R9: synchroniser latency on bank 1 inputs
    @(negedge clk);
    bus_addr = 8'h10;
    pad_in[15:8] = 8'h5A;
    @(negedge clk); @(negedge clk);
    check("R9 still old after two edges", NL'(bus_rdata), '0);
    @(negedge clk);
    check("R9 new level after three edges", NL'(bus_rdata), NL'(8'h5A));

    // R10: read register follows address one edge later
    @(negedge clk);
    bus_addr = 8'h08;
    check("R10 before edge holds old read", NL'(bus_rdata), NL'(8'h5A));
    @(negedge clk);
    check("R10 read after one edge", NL'(bus_rdata), NL'(8'hA5));

    // R7: preload latch of input lines, then switch to output
    bus_write(8'h18, 8'h81);
    check("R7 preload keeps pad disabled", NL'(pad_oe[23:16]), '0);
    check("R7 preload latch visible", NL'(pad_out[23:16]), NL'(8'h81));
    bus_write(8'h1C, 8'h00);
    check("R7 enable after switch", NL'(pad_oe[23:16]), NL'(8'hFF));
    check("R7 preloaded value driven", NL'(pad_out[23:16]), NL'(8'h81));

    // R8: unmapped and misaligned addresses
    bus_write(8'h1D, 8'hFF);
    check("R8 misaligned write ignored", NL'(pad_oe[23:16]), NL'(8'hFF));
    bus_read(8'h1D, rv);
    check("R8 misaligned reads zero", NL'(rv), '0);
    bus_write(8'hB8, 8'h00);
    bus_read(8'hB8, rv);
    check("R8 beyond last bank reads zero", NL'(rv), '0);
    bus_read(8'h90, rv);
    check("R8 window base reads zero", NL'(rv), '0);

    // R2: last bank line 0 input placement (dir 0x55 -> even lines input)
    @(negedge clk);
    pad_in[152] = 1'b1;
    bus_addr = 8'hB0;
    repeat (3) @(negedge clk);
    check("R2 R6 last bank input bit", NL'(bus_rdata), NL'(8'h01));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule